// File: doc/BRIEF.md
# Display Event Interrupt Controller

This block gathers the event pulses of a raster display engine (end of frame, FIFO underflow, palette fetch complete, loss of sync and frame complete) into a sticky status vector. An enable vector gates which of those sources may drive the single interrupt line. Software changes the enable vector only through two write-only strobe registers, one that turns bits on and one that turns bits off. It clears status by writing ones, and tells the controller it has finished servicing by writing an end-of-service register. That write disarms the line until a fresh enabled event arrives.

The block also watches for a flood of sync-loss events. Sync-loss events are counted while that source is enabled. The count restarts only at an end of frame whose whole frame saw no sync loss. When the count would pass its limit, the block drops the sync-loss enable on its own and raises a one-cycle recovery request, so that the system can restart the display pipeline.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset, status and enable are all zero, the line is low and the controller is armed.
- R2: A source pulse sets its status bit on the next clock edge whether or not the source is enabled. Bit positions: 0 end of frame, 1 FIFO underflow, 2 palette done, 3 sync lost, 4 frame done. A masked pulse never drives the line.
- R3: A write to the status address (0) clears every status bit that is one in the written data. A pulse that arrives in the same cycle as the clear of its own bit leaves the bit set.
- R4: A write to the enable-set address (2) turns on each enable bit that is one in the data. Zero bits leave their enables unchanged.
- R5: A write to the enable-clear address (3) turns off each enable bit that is one in the data. Zero bits leave their enables unchanged.
- R6: `irq_o` is high exactly when the controller is armed and some status bit is set whose enable is also set.
- R7: A write to the end-of-service address (4) disarms the controller from the next cycle. The controller re-arms on the edge after any cycle in which a pulse arrives on an enabled source. Such a pulse wins over an end-of-service write in the same cycle.
- R8: Sync-loss pulses are counted only while the sync-loss enable is set. The pulse that would take the count above SYNC_LIMIT (the 51st with the default) raises `recover_o` for that one cycle. On the next edge that pulse also clears the sync-loss enable and zeroes the count. The clear wins over a set in the same cycle.
- R9: An end-of-frame pulse zeroes the sync-loss count only when no counted sync-loss pulse has occurred since the previous end of frame. A sync-loss pulse in the same cycle as an end-of-frame pulse counts against the frame that follows.
- R10: Reads are combinational. Address 0 returns status, address 1 returns enable, address 5 returns status AND enable, and any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 5 | One-cycle event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | DATA_W | Read data |
| irq_o | output | 1 | Interrupt line |
| recover_o | output | 1 | One-cycle sync-flood recovery request |

## Verification
The assertions cover every cycle. They check that each pulse lands in status even when it is masked or cleared in the same cycle, and that the line is never high while the controller is disarmed or nothing enabled is pending. They also check that an end-of-service write with no enabled pulse silences the line on the next cycle, that a recovery request always removes the sync-loss enable, and that the enable vector moves only on a strobe or a recovery. The counting rules need long ordered stimulus that only the bench scenarios provide: a frame that is dirty versus clean, the exact pulse that trips the flood limit, and a re-arm that races an end-of-service write. The bench compares each of these against its behavioural model on every clock.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

  localparam int NSRC      = 5;
  localparam int SRC_EOF   = 0;
  localparam int SRC_UFLOW = 1;
  localparam int SRC_PAL   = 2;
  localparam int SRC_SYNC  = 3;
  localparam int SRC_FDONE = 4;

  typedef logic [NSRC-1:0] src_vec_t;

  typedef enum logic [2:0] {
    A_STATUS  = 3'd0,
    A_ENABLE  = 3'd1,
    A_EN_SET  = 3'd2,
    A_EN_CLR  = 3'd3,
    A_EOI     = 3'd4,
    A_PENDING = 3'd5
  } reg_addr_e;

  // sticky status: clear mask applied first, new pulses win
  function automatic src_vec_t status_next(src_vec_t cur, src_vec_t pulses, src_vec_t clr);
    return (cur & ~clr) | pulses;
  endfunction

  // enable: set mask applied first, clear mask wins
  function automatic src_vec_t enable_next(src_vec_t cur, src_vec_t set, src_vec_t clr);
    return (cur | set) & ~clr;
  endfunction

  function automatic src_vec_t pending(src_vec_t sts, src_vec_t en);
    return sts & en;
  endfunction

endpackage

// File: rtl/dic_status.sv
module dic_status
  import disp_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt_i,
  input  src_vec_t clr_i,
  output src_vec_t sts_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_o <= '0;
    else        sts_o <= status_next(sts_o, evt_i, clr_i);
  end

endmodule

// File: rtl/dic_enable.sv
module dic_enable
  import disp_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  input  logic     drop_sync_i,
  output src_vec_t en_o
);

  src_vec_t clr_all;

  always_comb begin
    clr_all = clr_i;
    if (drop_sync_i) clr_all[SRC_SYNC] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= '0;
    else        en_o <= enable_next(en_o, set_i, clr_all);
  end

endmodule

// File: rtl/dic_burst.sv
module dic_burst #(
  parameter int SYNC_LIMIT = 50,
  parameter int CNT_W      = $clog2(SYNC_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_evt_i,
  input  logic             eof_evt_i,
  output logic             burst_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(SYNC_LIMIT);

  logic clean_q;

  assign burst_o = sync_evt_i && (cnt_o == LIMIT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o   <= '0;
      clean_q <= 1'b1;
    end else begin
      if (burst_o)                    cnt_o <= '0;
      else if (sync_evt_i)            cnt_o <= cnt_o + 1'b1;
      else if (eof_evt_i && clean_q)  cnt_o <= '0;

      if (sync_evt_i)     clean_q <= 1'b0;
      else if (eof_evt_i) clean_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dic_arm.sv
module dic_arm
  import disp_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt_i,
  input  src_vec_t sts_i,
  input  src_vec_t en_i,
  input  logic     eoi_i,
  output logic     armed_o,
  output logic     irq_o
);

  logic fresh;

  assign fresh = |(evt_i & en_i);
  assign irq_o = armed_o && (|pending(sts_i, en_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_o <= 1'b1;
    else if (fresh) armed_o <= 1'b1;
    else if (eoi_i) armed_o <= 1'b0;
  end

endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import disp_irq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SYNC_LIMIT = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              recover_o
);

  localparam int CNT_W = $clog2(SYNC_LIMIT + 1);

  src_vec_t   wmask, sts_clr, en_set, en_clr, sts_q, en_q;
  logic       eoi_wr, burst_hit, armed_q, sync_evt;
  logic [CNT_W-1:0] cnt_q;

  assign wmask   = wr_data_i[NSRC-1:0];
  assign sts_clr = (wr_en_i && wr_addr_i == A_STATUS) ? wmask : '0;
  assign en_set  = (wr_en_i && wr_addr_i == A_EN_SET) ? wmask : '0;
  assign en_clr  = (wr_en_i && wr_addr_i == A_EN_CLR) ? wmask : '0;
  assign eoi_wr  = wr_en_i && wr_addr_i == A_EOI;

  generate
    if (DATA_W > NSRC) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wr_data_i[DATA_W-1:NSRC];
    end
  endgenerate

  assign sync_evt  = evt_i[SRC_SYNC] && en_q[SRC_SYNC];
  assign recover_o = burst_hit;

  dic_status u_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(sts_clr), .sts_o(sts_q)
  );

  dic_enable u_enable (
    .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr),
    .drop_sync_i(burst_hit), .en_o(en_q)
  );

  dic_burst #(.SYNC_LIMIT(SYNC_LIMIT), .CNT_W(CNT_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .sync_evt_i(sync_evt), .eof_evt_i(evt_i[SRC_EOF]),
    .burst_o(burst_hit), .cnt_o(cnt_q)
  );

  dic_arm u_arm (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sts_i(sts_q), .en_i(en_q),
    .eoi_i(eoi_wr), .armed_o(armed_q), .irq_o(irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_STATUS:  rd_data_o[NSRC-1:0] = sts_q;
      A_ENABLE:  rd_data_o[NSRC-1:0] = en_q;
      A_PENDING: rd_data_o[NSRC-1:0] = pending(sts_q, en_q);
      default:   rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/dic_checker.sv
module dic_checker
  import disp_irq_pkg::*;
#(
  parameter int SYNC_LIMIT = 50,
  parameter int CNT_W      = 6
) (
  input logic             clk,
  input logic             rst_n,
  input src_vec_t         evt_i,
  input src_vec_t         sts_q,
  input src_vec_t         en_q,
  input src_vec_t         en_set,
  input src_vec_t         en_clr,
  input logic             eoi_wr,
  input logic             armed_q,
  input logic             irq_o,
  input logic             recover_o,
  input logic [CNT_W-1:0] cnt_q
);

  assert_pulse_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

  assert_irq_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (armed_q && (|(sts_q & en_q))));

  assert_eoi_silences_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !(|(evt_i & en_q))) |=> !irq_o);

  assert_recover_drops_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recover_o |=> !en_q[SRC_SYNC]);

  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SYNC_LIMIT));

  assert_enable_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set == '0 && en_clr == '0 && !recover_o) |=> $stable(en_q));

endmodule

bind disp_irq_ctrl dic_checker #(.SYNC_LIMIT(SYNC_LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sts_q(sts_q), .en_q(en_q),
  .en_set(en_set), .en_clr(en_clr), .eoi_wr(eoi_wr), .armed_q(armed_q),
  .irq_o(irq_o), .recover_o(recover_o), .cnt_q(cnt_q)
);

// File: tb/disp_irq_ctrl_bench.sv
`timescale 1ns/1ps
module disp_irq_ctrl_bench;

  localparam int DW    = 8;
  localparam int LIMIT = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    evt = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq, recover;

  int checks = 0, errors = 0, ncyc = 0, nrecover = 0;

  // reference state
  int m_sts = 0, m_en = 0, m_armed = 1, m_cnt = 0, m_clean = 1;

  always #2.5 clk = ~clk;

  disp_irq_ctrl #(.DATA_W(DW), .SYNC_LIMIT(LIMIT)) u_disp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .recover_o(recover)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, ncyc);
    end
  endtask

  function automatic int model_read(input int a);
    if (a == 0) return m_sts;
    if (a == 1) return m_en;
    if (a == 5) return m_sts & m_en;
    return 0;
  endfunction

  // one cycle: drive at negedge, compare, advance model
  task automatic step(input int e, input int we, input int wa, input int wd, input int ra);
    int clr, set, eclr, eoi, sync_ev, burst, fresh;
    @(negedge clk);
    evt = e[4:0]; wr_en = we[0]; wr_addr = wa[2:0]; wr_data = wd[DW-1:0]; rd_addr = ra[2:0];
    #0.5;
    ncyc++;
    sync_ev = ((e >> 3) & 1) && ((m_en >> 3) & 1);
    burst   = sync_ev && (m_cnt == LIMIT);
    fresh   = (e & m_en) != 0;
    chk(int'(irq), (m_armed && ((m_sts & m_en) != 0)) ? 1 : 0, "R6 R7 irq");
    chk(int'(recover), burst, "R8 recover");
    chk(int'(rd_data), model_read(ra), "R10 R2 R3 R4 R5 read");
    if (recover) nrecover++;
    clr  = (we && wa == 0) ? (wd & 31) : 0;
    set  = (we && wa == 2) ? (wd & 31) : 0;
    eclr = (we && wa == 3) ? (wd & 31) : 0;
    eoi  = (we && wa == 4);
    m_sts = (m_sts & ~clr) | e;
    m_en  = m_en | set;
    m_en  = m_en & ~eclr;
    if (burst) m_en = m_en & ~8;
    if (fresh) m_armed = 1;
    else if (eoi) m_armed = 0;
    if (burst) m_cnt = 0;
    else if (sync_ev) m_cnt++;
    else if ((e & 1) && m_clean) m_cnt = 0;
    if (sync_ev) m_clean = 0;
    else if (e & 1) m_clean = 1;
  endtask

  task automatic idle(input int ra);
    step(0, 0, 0, 0, ra);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int nr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state observed at the ports
    chk(int'(irq), 0, "R1 irq after reset");
    chk(int'(rd_data), 0, "R1 status after reset");
    rst_n = 1'b1;
    idle(1);
    idle(5);

    // R2: masked pulses set status but leave line low
    step(31, 0, 0, 0, 0);
    idle(0);
    chk(int'(rd_data), 31, "R2 masked status");
    chk(int'(irq), 0, "R2 masked no irq");

    // R3: partial clear, then clear racing a new pulse
    step(0, 1, 0, 5, 0);
    idle(0);
    step(2, 1, 0, 2, 0);
    idle(0);
    chk(int'(rd_data), 26, "R3 same-cycle pulse kept");
    step(0, 1, 0, 255, 0);

    // R4/R5: set then clear with zero bits having no effect
    step(0, 1, 2, 5'b10110, 1);
    step(0, 1, 2, 0, 1);
    chk(int'(rd_data), 22, "R4 zero bits ignored on set");
    step(0, 1, 3, 5'b00100, 1);
    step(0, 1, 3, 0, 1);
    chk(int'(rd_data), 18, "R5 clear one bit");

    // R6/R7: event, service, rearm race
    step(16, 0, 0, 0, 5);
    idle(5);
    chk(int'(irq), 1, "R6 enabled pending raises line");
    step(0, 1, 4, 0, 0);
    idle(0);
    chk(int'(irq), 0, "R7 line low after service");
    step(1, 0, 0, 0, 0);     // masked source does not rearm
    idle(0);
    chk(int'(irq), 0, "R7 masked pulse no rearm");
    step(2, 1, 4, 0, 0);     // enabled pulse beats service write
    idle(0);
    chk(int'(irq), 1, "R7 rearm wins over service");
    step(0, 1, 0, 31, 0);
    step(0, 1, 4, 0, 0);

    // R8/R9: flood detection with dirty and clean frames
    step(0, 1, 2, 5'b01001, 1);
    nr = nrecover;
    repeat (30) step(8, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);      // dirty frame: count kept
    step(1, 0, 0, 0, 0);      // clean frame: count zeroed
    repeat (50) step(8, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);      // dirty: count stays 50
    step(8, 0, 0, 0, 1);      // 51st trips
    chk(nrecover - nr, 1, "R9 one recovery after clean-frame reset");
    idle(1);
    chk(int'(rd_data) & 8, 0, "R8 sync enable dropped");
    step(8, 0, 0, 0, 1);      // disabled: not counted
    chk(int'(recover), 0, "R8 no count while disabled");

    // mixed stimulus against the model
    for (int i = 0; i < 4000; i++) begin
      int e, we, wa, wd;
      e  = 0;
      for (int b = 0; b < 5; b++) if ($urandom_range(0, 7) == 0) e |= (1 << b);
      if ($urandom_range(0, 2) == 0) e |= 8;
      if ($urandom_range(0, 40) != 0) e &= ~1;
      we = ($urandom_range(0, 3) == 0);
      wa = $urandom_range(0, 5);
      wd = $urandom_range(0, 255);
      step(e, we, wa, wd, $urandom_range(0, 7));
    end

    finish_run();
  end

endmodule